// File: doc/BRIEF.md
# Dual-Plane RAM Window with Attribute Latch

This block sits on a CPU bus and holds two RAM planes. One is a byte-wide main plane. The other is an attribute plane whose data width is a parameter and defaults to 4 bits. Each plane answers at its own direct memory range: the main plane at 0x4000–0x7FFF and the attribute plane at 0x8000–0xBFFF. Inside each range the plane repeats every 2^PLANE_AW bytes. A third memory range, 0xC000–0xDFFF, is a combined window that reaches both planes at once. The window offset is the address minus 0xC000, reduced modulo the plane depth.

An 8-bit attribute latch carries data between the attribute plane and the CPU. A window read returns the main byte and also copies the attribute at the same offset into the latch. A window write stores the CPU byte into the main plane and the low bits of the latch into the attribute plane. The CPU can read and write the latch directly as I/O port 0xE0. A debug flag turns a window read into one with no side effect, so an inspector can look at memory without changing the latch.

A bus cycle lasts one clock. `mem_sel` marks a memory cycle, `io_sel` marks an I/O cycle, and `wr_en` picks write over read. Read data and `rvalid` come out on the clock edge after the cycle.

Top module: `twin_plane_ram`

## Requirements
- R1: While `rst` is high, on the clock edges that follow, `rvalid` is 0 and `rdata` is 0x00. After reset, the latch reads back as 0x00 through port 0xE0.
- R2: A memory write in 0x4000–0x7FFF stores `wdata` into the main plane at (address − 0x4000) mod 2^PLANE_AW. A memory read there returns that byte on `rdata` after the next clock edge, so with the default depth 0x4405 returns what was written to 0x4005.
- R3: A memory write in 0x8000–0xBFFF stores the low EXTRA_W bits of `wdata` into the attribute plane. A direct read there returns the stored bits with the upper 8−EXTRA_W bits of `rdata` at zero: writing 0x3C reads back 0x0C.
- R4: A memory read in 0xC000–0xDFFF returns the main-plane byte at (address − 0xC000) mod 2^PLANE_AW. This holds up to and including 0xDFFF.
- R5: A window read without `dbg_rd` loads the latch with the attribute at the same offset, zero-extended. An I/O read of port 0xE0 in the very next cycle returns the new value.
- R6: A window write stores `wdata` into the main plane and the low EXTRA_W bits of the current latch value into the attribute plane, both at the same offset. The current value includes a load or a port write made in the cycle just before.
- R7: An I/O write to port 0xE0 (`addr[7:0]` == 0xE0) sets the latch to `wdata`, and an I/O read of port 0xE0 returns the latch.
- R8: A window read with `dbg_rd` high returns the main byte and leaves the latch unchanged.
- R9: An I/O cycle at a window address touches neither plane. A memory cycle at address 0x00E0 leaves the latch unchanged.
- R10: A memory read outside the three ranges, and an I/O read of any port other than 0xE0, returns 0x00. Writes there have no effect.
- R11: `rvalid` is 1 exactly on the clock edge after a read cycle, and 0 after write cycles and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_sel | input | 1 | Memory-space cycle strobe |
| io_sel | input | 1 | I/O-space cycle strobe (ignored while `mem_sel` is high) |
| wr_en | input | 1 | 1 = write cycle, 0 = read cycle |
| dbg_rd | input | 1 | Side-effect-free read; suppresses the latch load of a window read |
| addr | input | 16 | Memory address; I/O port number in bits 7:0 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid on the edge after the read cycle |
| rvalid | output | 1 | Marks `rdata` as carrying a read result |

## Verification
On every cycle the assertions check the following:
- the reset output state;
- the `rvalid` timing;
- zero data from unmapped reads;
- the zero upper bits on direct attribute reads;
- that a port write reaches the latch;
- that a window read arms the load;
- that debug reads and memory cycles leave the latch untouched.

Only the bench scenarios can show the rest:
- where data lands inside the planes, including mirroring and the 0xDFFF boundary;
- which attribute value a window read loads;
- the forwarding of a load or port write into a window write issued in the next cycle.

// File: rtl/twin_plane_pkg.sv
package twin_plane_pkg;
  typedef enum logic [2:0] {
    RG_NONE  = 3'd0,
    RG_MAIN  = 3'd1,
    RG_EXTRA = 3'd2,
    RG_WIN   = 3'd3,
    RG_PORT  = 3'd4
  } region_e;
endpackage

// File: rtl/twin_plane_decode.sv
module twin_plane_decode
  import twin_plane_pkg::*;
#(
  parameter int          PLANE_AW  = 10,
  parameter logic [15:0] MAIN_LO   = 16'h4000,
  parameter logic [15:0] MAIN_HI   = 16'h7FFF,
  parameter logic [15:0] EXTRA_LO  = 16'h8000,
  parameter logic [15:0] EXTRA_HI  = 16'hBFFF,
  parameter logic [15:0] WIN_LO    = 16'hC000,
  parameter logic [15:0] WIN_HI    = 16'hDFFF,
  parameter logic [7:0]  PORT_ADDR = 8'hE0
) (
  input  logic                mem_sel,
  input  logic                io_sel,
  input  logic [15:0]         addr,
  output region_e             region,
  output logic [PLANE_AW-1:0] offset
);
  always_comb begin
    region = RG_NONE;
    if (mem_sel) begin
      if (addr >= MAIN_LO && addr <= MAIN_HI)        region = RG_MAIN;
      else if (addr >= EXTRA_LO && addr <= EXTRA_HI) region = RG_EXTRA;
      else if (addr >= WIN_LO && addr <= WIN_HI)     region = RG_WIN;
    end else if (io_sel && addr[7:0] == PORT_ADDR) begin
      region = RG_PORT;
    end
  end

  // Offset relative to the matched range base, modulo plane depth.
  always_comb begin
    unique case (region)
      RG_MAIN:  offset = addr[PLANE_AW-1:0] - MAIN_LO[PLANE_AW-1:0];
      RG_EXTRA: offset = addr[PLANE_AW-1:0] - EXTRA_LO[PLANE_AW-1:0];
      RG_WIN:   offset = addr[PLANE_AW-1:0] - WIN_LO[PLANE_AW-1:0];
      default:  offset = addr[PLANE_AW-1:0];
    endcase
  end
endmodule

// File: rtl/twin_plane_mem.sv
module twin_plane_mem #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] a,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // Single-port, registered read: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (we) cells[a] <= wd;
    if (re) q <= cells[a];
  end
endmodule

// File: rtl/twin_plane_latch.sv
module twin_plane_latch #(
  parameter int EXTRA_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               port_we,
  input  logic [7:0]         port_wd,
  input  logic               load_req,
  input  logic [EXTRA_W-1:0] extra_q,
  output logic [7:0]         extra_wide,
  output logic [7:0]         latch_eff,
  output logic [7:0]         latch_q,
  output logic               load_pend
);
  generate
    if (EXTRA_W < 8) begin : g_narrow
      assign extra_wide = {{(8-EXTRA_W){1'b0}}, extra_q};
    end else begin : g_full
      assign extra_wide = extra_q;
    end
  endgenerate

  // The plane read lands one edge late; forward it until it is absorbed.
  assign latch_eff = load_pend ? extra_wide : latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_pend <= 1'b0;
      latch_q   <= 8'h00;
    end else begin
      load_pend <= load_req;
      if (port_we)        latch_q <= port_wd;
      else if (load_pend) latch_q <= extra_wide;
    end
  end
endmodule

// File: rtl/twin_plane_ram.sv
module twin_plane_ram
  import twin_plane_pkg::*;
#(
  parameter int          PLANE_AW  = 10,
  parameter int          EXTRA_W   = 4,
  parameter logic [15:0] MAIN_LO   = 16'h4000,
  parameter logic [15:0] MAIN_HI   = 16'h7FFF,
  parameter logic [15:0] EXTRA_LO  = 16'h8000,
  parameter logic [15:0] EXTRA_HI  = 16'hBFFF,
  parameter logic [15:0] WIN_LO    = 16'hC000,
  parameter logic [15:0] WIN_HI    = 16'hDFFF,
  parameter logic [7:0]  PORT_ADDR = 8'hE0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mem_sel,
  input  logic        io_sel,
  input  logic        wr_en,
  input  logic        dbg_rd,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        rvalid
);
  region_e             region;
  logic [PLANE_AW-1:0] offset;
  logic                rd_cyc, wr_cyc;
  logic                main_hit, extra_hit, win_hit, port_hit;
  logic [7:0]          main_q;
  logic [EXTRA_W-1:0]  extra_q;
  logic [EXTRA_W-1:0]  extra_wd;
  logic [7:0]          extra_wide, latch_eff, latch_q;
  logic                load_pend;
  region_e             src_r;
  logic [7:0]          port_r;

  twin_plane_decode #(
    .PLANE_AW(PLANE_AW), .MAIN_LO(MAIN_LO), .MAIN_HI(MAIN_HI),
    .EXTRA_LO(EXTRA_LO), .EXTRA_HI(EXTRA_HI), .WIN_LO(WIN_LO),
    .WIN_HI(WIN_HI), .PORT_ADDR(PORT_ADDR)
  ) u_decode (
    .mem_sel(mem_sel), .io_sel(io_sel), .addr(addr),
    .region(region), .offset(offset)
  );

  assign rd_cyc    = (mem_sel | io_sel) & ~wr_en;
  assign wr_cyc    = (mem_sel | io_sel) & wr_en;
  assign main_hit  = (region == RG_MAIN);
  assign extra_hit = (region == RG_EXTRA);
  assign win_hit   = (region == RG_WIN);
  assign port_hit  = (region == RG_PORT);

  twin_plane_mem #(.AW(PLANE_AW), .DW(8)) u_main (
    .clk(clk),
    .we (wr_cyc & (main_hit | win_hit)),
    .re (rd_cyc & (main_hit | win_hit)),
    .a  (offset),
    .wd (wdata),
    .q  (main_q)
  );

  assign extra_wd = win_hit ? latch_eff[EXTRA_W-1:0] : wdata[EXTRA_W-1:0];

  twin_plane_mem #(.AW(PLANE_AW), .DW(EXTRA_W)) u_extra (
    .clk(clk),
    .we (wr_cyc & (extra_hit | win_hit)),
    .re (rd_cyc & (extra_hit | win_hit)),
    .a  (offset),
    .wd (extra_wd),
    .q  (extra_q)
  );

  twin_plane_latch #(.EXTRA_W(EXTRA_W)) u_latch (
    .clk(clk),
    .rst(rst),
    .port_we(wr_cyc & port_hit),
    .port_wd(wdata),
    .load_req(rd_cyc & win_hit & ~dbg_rd),
    .extra_q(extra_q),
    .extra_wide(extra_wide),
    .latch_eff(latch_eff),
    .latch_q(latch_q),
    .load_pend(load_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_r  <= RG_NONE;
      port_r <= 8'h00;
      rvalid <= 1'b0;
    end else begin
      src_r  <= rd_cyc ? region : RG_NONE;
      port_r <= latch_eff;
      rvalid <= rd_cyc;
    end
  end

  always_comb begin
    unique case (src_r)
      RG_MAIN, RG_WIN: rdata = main_q;
      RG_EXTRA:        rdata = extra_wide;
      RG_PORT:         rdata = port_r;
      default:         rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/twin_plane_chk.sv
module twin_plane_chk #(
  parameter int          EXTRA_W   = 4,
  parameter logic [15:0] MAIN_LO   = 16'h4000,
  parameter logic [15:0] EXTRA_LO  = 16'h8000,
  parameter logic [15:0] EXTRA_HI  = 16'hBFFF,
  parameter logic [15:0] WIN_LO    = 16'hC000,
  parameter logic [15:0] WIN_HI    = 16'hDFFF,
  parameter logic [7:0]  PORT_ADDR = 8'hE0
) (
  input logic        clk,
  input logic        rst,
  input logic        mem_sel,
  input logic        io_sel,
  input logic        wr_en,
  input logic        dbg_rd,
  input logic [15:0] addr,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic        rvalid,
  input logic [7:0]  latch_q,
  input logic        load_pend
);
  logic rd_c, win_rd, port_wr;
  assign rd_c    = (mem_sel | io_sel) & ~wr_en;
  assign win_rd  = mem_sel & ~wr_en & addr >= WIN_LO & addr <= WIN_HI;
  assign port_wr = io_sel & ~mem_sel & wr_en & addr[7:0] == PORT_ADDR;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!rvalid && rdata == 8'h00));

  p_valid_after_read_r11: assert property (@(posedge clk) disable iff (rst)
    rd_c |=> rvalid);

  p_no_valid_otherwise_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_c |=> !rvalid);

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_sel && !wr_en && addr < MAIN_LO) |=> rdata == 8'h00);

  p_extra_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_sel && !wr_en && addr >= EXTRA_LO && addr <= EXTRA_HI)
      |=> (rdata >> EXTRA_W) == 8'h00);

  p_port_write_r7: assert property (@(posedge clk) disable iff (rst)
    port_wr |=> latch_q == $past(wdata));

  p_window_load_r5: assert property (@(posedge clk) disable iff (rst)
    (win_rd && !dbg_rd) |=> load_pend);

  p_debug_keeps_latch_r8: assert property (@(posedge clk) disable iff (rst)
    (win_rd && dbg_rd && !load_pend) |=> $stable(latch_q));

  p_mem_skips_latch_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_sel && !load_pend) |=> $stable(latch_q));
endmodule

bind twin_plane_ram twin_plane_chk #(
  .EXTRA_W(EXTRA_W), .MAIN_LO(MAIN_LO), .EXTRA_LO(EXTRA_LO),
  .EXTRA_HI(EXTRA_HI), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
  .PORT_ADDR(PORT_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .mem_sel(mem_sel), .io_sel(io_sel),
  .wr_en(wr_en), .dbg_rd(dbg_rd), .addr(addr), .wdata(wdata),
  .rdata(rdata), .rvalid(rvalid), .latch_q(latch_q),
  .load_pend(load_pend)
);

// File: tb/test_twin_plane_ram.sv
module test_twin_plane_ram;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_sel = 1'b0, io_sel = 1'b0, wr_en = 1'b0, dbg_rd = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        rvalid;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  twin_plane_ram i_twin_plane_ram (
    .clk(clk), .rst(rst), .mem_sel(mem_sel), .io_sel(io_sel),
    .wr_en(wr_en), .dbg_rd(dbg_rd), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    logic        io;
    logic        wr;
    logic        dbg;
    logic [15:0] a;
    logic [7:0]  wd;
    logic [7:0]  exp;
    logic        chk;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,16'h4005,8'hA5,8'h00,1'b0,4'd2},  // R2 main write
    '{1'b0,1'b0,1'b0,16'h4005,8'h00,8'hA5,1'b1,4'd2},  // R2 main read
    '{1'b0,1'b0,1'b0,16'h4405,8'h00,8'hA5,1'b1,4'd2},  // R2 mirror
    '{1'b0,1'b1,1'b0,16'h8005,8'h3C,8'h00,1'b0,4'd3},  // R3 attr write
    '{1'b0,1'b0,1'b0,16'h8005,8'h00,8'h0C,1'b1,4'd3},  // R3 upper nibble zero
    '{1'b0,1'b0,1'b0,16'h8405,8'h00,8'h0C,1'b1,4'd3},  // R3 mirror
    '{1'b0,1'b0,1'b0,16'hC005,8'h00,8'hA5,1'b1,4'd4},  // R4 window read
    '{1'b1,1'b0,1'b0,16'h00E0,8'h00,8'h0C,1'b1,4'd5},  // R5 latch loaded
    '{1'b1,1'b1,1'b0,16'h00E0,8'h97,8'h00,1'b0,4'd7},  // R7 port write
    '{1'b1,1'b0,1'b0,16'h00E0,8'h00,8'h97,1'b1,4'd7},  // R7 port read
    '{1'b0,1'b1,1'b0,16'hC010,8'h5A,8'h00,1'b0,4'd6},  // R6 window write
    '{1'b0,1'b0,1'b0,16'h4010,8'h00,8'h5A,1'b1,4'd6},  // R6 main side
    '{1'b0,1'b0,1'b0,16'h8010,8'h00,8'h07,1'b1,4'd6},  // R6 attr gets latch
    '{1'b0,1'b0,1'b1,16'hC005,8'h00,8'hA5,1'b1,4'd8},  // R8 debug read
    '{1'b1,1'b0,1'b0,16'h00E0,8'h00,8'h97,1'b1,4'd8},  // R8 latch kept
    '{1'b1,1'b1,1'b0,16'hC010,8'hFF,8'h00,1'b0,4'd9},  // R9 io at window addr
    '{1'b0,1'b0,1'b0,16'h4010,8'h00,8'h5A,1'b1,4'd9},  // R9 main untouched
    '{1'b0,1'b0,1'b0,16'h8010,8'h00,8'h07,1'b1,4'd9},  // R9 attr untouched
    '{1'b0,1'b1,1'b0,16'h00E0,8'h11,8'h00,1'b0,4'd9},  // R9 mem at 0x00E0
    '{1'b1,1'b0,1'b0,16'h00E0,8'h00,8'h97,1'b1,4'd9},  // R9 latch kept
    '{1'b0,1'b0,1'b0,16'h00E0,8'h00,8'h00,1'b1,4'd10}, // R10 unmapped low
    '{1'b0,1'b0,1'b0,16'hE000,8'h00,8'h00,1'b1,4'd10}, // R10 above window
    '{1'b1,1'b0,1'b0,16'h0041,8'h00,8'h00,1'b1,4'd10}, // R10 other port
    '{1'b0,1'b0,1'b0,16'hC005,8'h00,8'hA5,1'b1,4'd4},  // R4 load 0x0C
    '{1'b0,1'b1,1'b0,16'hC020,8'h01,8'h00,1'b0,4'd6},  // R6 forwarded load
    '{1'b0,1'b0,1'b0,16'h8020,8'h00,8'h0C,1'b1,4'd6},
    '{1'b1,1'b1,1'b0,16'h00E0,8'hF6,8'h00,1'b0,4'd7},  // R7 then window write
    '{1'b0,1'b1,1'b0,16'hC030,8'h22,8'h00,1'b0,4'd6},  // R6 forwarded port
    '{1'b0,1'b0,1'b0,16'h8030,8'h00,8'h06,1'b1,4'd6},
    '{1'b0,1'b0,1'b0,16'h4030,8'h00,8'h22,1'b1,4'd6},
    '{1'b0,1'b1,1'b0,16'h7FFF,8'h3E,8'h00,1'b0,4'd4},  // R4 top of window
    '{1'b0,1'b1,1'b0,16'hBFFF,8'h09,8'h00,1'b0,4'd5},
    '{1'b0,1'b0,1'b0,16'hDFFF,8'h00,8'h3E,1'b1,4'd4},  // R4 0xDFFF
    '{1'b1,1'b0,1'b0,16'h00E0,8'h00,8'h09,1'b1,4'd5}   // R5 load at 0xDFFF
  };

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  // Drive one bus cycle starting at a falling edge; returns at the next
  // falling edge, after the edge that registers the result.
  task automatic bus(input logic io, input logic wr, input logic dbg,
                     input logic [15:0] a, input logic [7:0] wd);
    mem_sel = ~io; io_sel = io; wr_en = wr; dbg_rd = dbg; addr = a; wdata = wd;
    @(posedge clk);
    @(negedge clk);
    mem_sel = 1'b0; io_sel = 1'b0; wr_en = 1'b0; dbg_rd = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    check8("R1 rdata in reset", rdata, 8'h00);
    check8("R1 rvalid in reset", {7'd0, rvalid}, 8'h00);
    rst = 1'b0;
    bus(1'b1, 1'b0, 1'b0, 16'h00E0, 8'h00);
    check8("R1 latch after reset", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      bus(VECS[i].io, VECS[i].wr, VECS[i].dbg, VECS[i].a, VECS[i].wd);
      if (VECS[i].chk)
        check8($sformatf("R%0d vector %0d rdata", VECS[i].req, i), rdata, VECS[i].exp);
      check8($sformatf("R11 vector %0d rvalid", i), {7'd0, rvalid}, {7'd0, ~VECS[i].wr});
    end

    // R11: idle cycle drops rvalid
    idle();
    check8("R11 idle rvalid", {7'd0, rvalid}, 8'h00);
    check8("R10 idle rdata", rdata, 8'h00);

    // R1: mid-run reset clears the latch
    bus(1'b1, 1'b1, 1'b0, 16'h00E0, 8'h55);
    rst = 1'b1;
    idle();
    check8("R1 rvalid under reset", {7'd0, rvalid}, 8'h00);
    rst = 1'b0;
    bus(1'b1, 1'b0, 1'b0, 16'h00E0, 8'h00);
    check8("R1 latch cleared", rdata, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule